// File: doc/BRIEF.md
# CPU Reset and Request Sequencer

This block sits next to a 16-bit execution core and decides, at every instruction boundary, what the core does next. There are four choices: re-enter reset, grant the bus to an external master, enter an interrupt, or run the next instruction. Between boundaries the block counts down the cycles that the chosen action costs. A free-running cycle counter gives every decision its time base.

Bus and interrupt requests arrive as time windows. Each window has a type, a start cycle and an end cycle, and the windows wait in a small queue. Only the oldest request is considered. When it is acknowledged inside its window, it is retired. If the counter reaches its end first, it is discarded with a drop pulse.

The core reports three things for each instruction: its cycle cost, whether it may be interrupted, and whether it arms a deferral. The sequencer keeps the program counter, the stack pointer and a one-hot deferral register up to date. During interrupt entry it issues the stack write of the return address.

Top module: `boundary_sequencer`

## Requirements
- R1: At a reset boundary `pc` becomes 0x1000. After the reset that follows `rst_n`, the next boundary is one cycle later. A pulse on `reset_req` is serviced at the first boundary where `reset_req` is low, and that boundary is followed by exactly 5 cycles with `dead` high.
- R2: A pending reset is serviced ahead of any queued request, even one whose window is open. Reset clears both interruptibility latches, so the first boundary after the dead cycles runs an instruction and grants nothing. `sp` is not changed by reset.
- R3: A bus request (`req_is_bus`=1) is granted at a boundary when the queue front is a bus request, `start <= now < end`, and the bus latch is set. `busak` is then high from that cycle through cycle `end-1`, and the next boundary falls on cycle `end`.
- R4: When an interrupt request is granted at cycle T, `intak` and `stk_we` are high in cycle T+2, with `stk_addr`=`sp` and `stk_data`=`pc`. `sp` then increments by one. The next boundary is T+12, and there `pc` equals `int_vec`.
- R5: At a boundary where `now >= end` for the queue front, `drop` pulses for one cycle and the entry is removed with no acknowledge. The next boundary is the following cycle.
- R6: A request whose window has not yet opened is not acknowledged. The core keeps running, one instruction per boundary.
- R7: Each executed instruction latches two flags. The bus latch takes `instr_intr`. The interrupt latch takes `instr_intr AND int_en`. A bus grant needs the bus latch, and an interrupt grant needs the interrupt latch.
- R8: A boundary with nothing else to do pulses `exec` and increments `pc`. The next boundary comes `ins_cycles` cycles later; a value of 0 counts as 1.
- R9: On every `exec`, `defer` is loaded with `(defer_arm ? 1<<(DW-1) : defer) >> 1`, so it shifts right by one each instruction.
- R10: The queue holds QD=4 requests in arrival order. Only the front entry is evaluated. A push made while 4 entries are held is discarded.
- R11: `now` is 0 in reset and increments by one on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reset_req | input | 1 | Request a CPU reset, serviced after it falls |
| req_push | input | 1 | Enqueue a request descriptor this cycle |
| req_is_bus | input | 1 | 1 = bus request, 0 = interrupt request |
| req_start | input | CW | First cycle of the request window |
| req_end | input | CW | Cycle at which the window closes (exclusive) |
| int_en | input | 1 | Interrupt enable flag from the core |
| instr_intr | input | 1 | Current instruction is interruptible |
| defer_arm | input | 1 | Current instruction arms the deferral register |
| ins_cycles | input | 4 | Cycle cost reported for the current instruction |
| int_vec | input | AW | Interrupt vector address |
| busak | output | 1 | Bus granted, held for the stall |
| intak | output | 1 | Interrupt acknowledge pulse |
| drop | output | 1 | Front request expired and discarded |
| dead | output | 1 | Dead or stall cycle of reset, bus or interrupt |
| exec | output | 1 | Instruction issued at this boundary |
| stk_we | output | 1 | Stack write strobe |
| stk_addr | output | AW | Stack write address |
| stk_data | output | AW | Stack write data (return PC) |
| pc | output | AW | Program counter |
| sp | output | AW | Stack pointer |
| now | output | CW | Cycle counter |
| defer | output | DW | One-hot deferral register |

## Verification
A vector table of instruction costs and deferral arms, including costs of 0 and 1, shows that the boundary spacing, the program counter steps and the deferral shift are each correct. Bus and interrupt windows are placed a few cycles ahead while instructions run every cycle. The grant cycle then pins down the start comparison, and the stall or entry length pins down the end comparison and the fixed 12-cycle budget. The same windows are offered again with the relevant latch cleared, which separates the gating from the window logic: each must lead to a drop at the window end. A reset raised together with an open bus window shows that reset wins, that the dead budget is correct and that the latches are cleared. A burst of expired requests pushed during a long instruction measures the queue depth.

// File: rtl/boundary_sequencer.sv
module boundary_sequencer #(
  parameter int CW = 16,
  parameter int AW = 16,
  parameter int QD = 4,
  parameter int DW = 2,
  parameter int RST_DEAD = 5,
  parameter int INT_PRE = 2,
  parameter int INT_TOTAL = 12,
  parameter logic [AW-1:0] RST_PC = 16'h1000,
  parameter logic [AW-1:0] SP_RESET = 16'h0200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reset_req,
  input  logic          req_push,
  input  logic          req_is_bus,
  input  logic [CW-1:0] req_start,
  input  logic [CW-1:0] req_end,
  input  logic          int_en,
  input  logic          instr_intr,
  input  logic          defer_arm,
  input  logic [3:0]    ins_cycles,
  input  logic [AW-1:0] int_vec,
  output logic          busak,
  output logic          intak,
  output logic          drop,
  output logic          dead,
  output logic          exec,
  output logic          stk_we,
  output logic [AW-1:0] stk_addr,
  output logic [AW-1:0] stk_data,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] sp,
  output logic [CW-1:0] now,
  output logic [DW-1:0] defer
);
  localparam int QAW = $clog2(QD);
  localparam logic [QAW:0]   QFULL = (QAW+1)'(QD);
  localparam logic [CW-1:0]  L_RST = CW'(RST_DEAD);
  localparam logic [CW-1:0]  L_INT = CW'(INT_TOTAL - 1);
  localparam logic [CW-1:0]  L_ACK = CW'(INT_TOTAL - INT_PRE);
  localparam logic [DW-1:0]  D_TOP = DW'(1) << (DW - 1);

  typedef enum logic [1:0] {M_EXEC, M_RST, M_BUS, M_INT} mode_t;

  logic [CW-1:0]  q_st [QD];
  logic [CW-1:0]  q_en [QD];
  logic           q_bus [QD];
  logic [QAW-1:0] hd, tl;
  logic [QAW:0]   cnt;
  mode_t          mode;
  logic [CW-1:0]  left;
  logic           pend, booted, ok_bus, ok_irq;

  logic boundary, has, in_win, late, do_rst, g_bus, g_int, pop, push_ok;
  logic [CW-1:0] f_st, f_en;
  logic f_bus;

  assign f_st     = q_st[hd];
  assign f_en     = q_en[hd];
  assign f_bus    = q_bus[hd];
  assign has      = cnt != '0;
  assign boundary = left == '0;
  assign in_win   = has && f_st <= now && now < f_en;
  assign late     = has && now >= f_en;
  assign do_rst   = boundary && pend && !reset_req;
  assign g_bus    = boundary && !do_rst && in_win && f_bus && ok_bus;
  assign g_int    = boundary && !do_rst && in_win && !f_bus && ok_irq;
  assign drop     = boundary && !do_rst && late;
  assign exec     = boundary && !do_rst && !g_bus && !g_int && !late;
  assign pop      = g_bus || g_int || drop;
  assign push_ok  = req_push && cnt != QFULL;

  assign busak    = g_bus || (mode == M_BUS && left != '0);
  assign intak    = mode == M_INT && left == L_ACK;
  assign dead     = mode != M_EXEC && left != '0;
  assign stk_we   = intak;
  assign stk_addr = sp;
  assign stk_data = pc;

  always_ff @(posedge clk) begin
    if (push_ok) begin
      q_st[tl]  <= req_start;
      q_en[tl]  <= req_end;
      q_bus[tl] <= req_is_bus;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd  <= '0;
      tl  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) tl <= tl + QAW'(1);
      if (pop)     hd <= hd + QAW'(1);
      cnt <= cnt + {{QAW{1'b0}}, push_ok} - {{QAW{1'b0}}, pop};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now    <= '0;
      left   <= '0;
      mode   <= M_EXEC;
      pend   <= 1'b1;
      booted <= 1'b0;
      ok_bus <= 1'b0;
      ok_irq <= 1'b0;
      pc     <= '0;
      sp     <= SP_RESET;
      defer  <= '0;
    end else begin
      now <= now + CW'(1);
      if (reset_req) pend <= 1'b1;
      if (left != '0) left <= left - CW'(1);
      if (mode == M_INT && left == CW'(1)) pc <= int_vec;
      if (intak) sp <= sp + AW'(1);
      if (do_rst) begin
        pc     <= RST_PC;
        pend   <= 1'b0;
        booted <= 1'b1;
        ok_bus <= 1'b0;
        ok_irq <= 1'b0;
        mode   <= M_RST;
        left   <= booted ? L_RST : '0;
      end else if (g_bus) begin
        mode <= M_BUS;
        left <= f_en - now - CW'(1);
      end else if (g_int) begin
        mode <= M_INT;
        left <= L_INT;
      end else if (exec) begin
        pc     <= pc + AW'(1);
        ok_bus <= instr_intr;
        ok_irq <= instr_intr && int_en;
        defer  <= (defer_arm ? D_TOP : defer) >> 1;
        mode   <= M_EXEC;
        left   <= (ins_cycles == 4'd0) ? '0 : CW'(ins_cycles - 4'd1);
      end else if (drop) begin
        mode <= M_EXEC;
      end
    end
  end
endmodule

// File: rtl/boundary_sequencer_chk.sv
module boundary_sequencer_chk #(
  parameter int CW = 16,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busak,
  input logic          intak,
  input logic          drop,
  input logic          dead,
  input logic          exec,
  input logic [AW-1:0] sp,
  input logic [CW-1:0] now
);
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({busak, exec, drop})); // R5
  AST_EXEC_LIVE: assert property (@(posedge clk) disable iff (!rst_n) exec |-> !dead); // R8
  AST_INTAK_DEAD: assert property (@(posedge clk) disable iff (!rst_n) intak |-> dead && $past(dead)); // R4
  AST_INTAK_SP: assert property (@(posedge clk) disable iff (!rst_n) intak |=> sp == $past(sp) + AW'(1)); // R4
  AST_SP_STILL: assert property (@(posedge clk) disable iff (!rst_n) !intak |=> $stable(sp)); // R2
  AST_NOW_STEP: assert property (@(posedge clk) disable iff (!rst_n) rst_n |=> now == $past(now) + CW'(1)); // R11
  AST_BUSAK_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(busak) |-> !dead); // R3
endmodule

bind boundary_sequencer boundary_sequencer_chk #(.CW(CW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .busak(busak), .intak(intak), .drop(drop),
  .dead(dead), .exec(exec), .sp(sp), .now(now)
);

// File: tb/boundary_sequencer_tb_top.sv
module boundary_sequencer_tb_top;
  localparam logic [15:0] SPI = 16'h0200;
  localparam logic [15:0] VEC = 16'h2000;
  localparam int NT = 6;
  localparam logic [4:0] TBL [NT] = '{5'h13, 5'h01, 5'h00, 5'h15, 5'h12, 5'h07};

  logic clk = 1'b0, rst_n = 1'b0;
  logic reset_req = 0, req_push = 0, req_is_bus = 0, int_en = 0, instr_intr = 0, defer_arm = 0;
  logic [15:0] req_start = '0, req_end = '0;
  logic [3:0] ins_cycles = 4'd1;
  logic busak, intak, drop, dead, exec, stk_we;
  logic [15:0] stk_addr, stk_data, pc, sp, now;
  logic [1:0] defer;

  logic nx_reset = 0, nx_push = 0, nx_bus = 0, nx_ien = 0, nx_iok = 0, nx_arm = 0;
  logic [15:0] nx_s = '0, nx_e = '0;
  logic [3:0] nx_cyc = 4'd1;

  int checks = 0, fails = 0, cyc = 0;

  boundary_sequencer #(.SP_RESET(SPI)) dut_i (
    .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .req_push(req_push),
    .req_is_bus(req_is_bus), .req_start(req_start), .req_end(req_end),
    .int_en(int_en), .instr_intr(instr_intr), .defer_arm(defer_arm),
    .ins_cycles(ins_cycles), .int_vec(VEC), .busak(busak), .intak(intak),
    .drop(drop), .dead(dead), .exec(exec), .stk_we(stk_we), .stk_addr(stk_addr),
    .stk_data(stk_data), .pc(pc), .sp(sp), .now(now), .defer(defer)
  );

  always #2 clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    reset_req = nx_reset; req_push = nx_push; req_is_bus = nx_bus;
    req_start = nx_s; req_end = nx_e; int_en = nx_ien; instr_intr = nx_iok;
    defer_arm = nx_arm; ins_cycles = nx_cyc;
    #1;
  endtask

  task automatic wait_exec();
    int n = 0;
    do begin step(); n++; end while (!exec && n < 100);
    if (!exec) check_eq("exec reached", 0, 1);
  endtask

  task automatic push(input logic b, input int s, input int e);
    nx_bus = b; nx_s = 16'(s); nx_e = 16'(e); nx_push = 1;
    step();
    nx_push = 0;
  endtask

  initial begin
    int t_prev, pc_prev, base, cnt, sp0, pcg, first;
    logic [1:0] dm;
    repeat (3) @(posedge clk);
    #2;
    check_eq("R11 now in reset", int'(now), 0);
    check_eq("R11 pc in reset", int'(pc), 0);
    check_eq("R11 sp in reset", int'(sp), int'(SPI));
    check_eq("R11 no strobes in reset", int'({busak, intak, drop, exec}), 0);
    @(posedge clk); #1 rst_n = 1; #1;
    check_eq("R1 first reset cycle idle", int'({exec, dead}), 0);
    step();
    check_eq("R1 first exec after power-up", int'(exec), 1);
    check_eq("R1 pc after reset", int'(pc), 16'h1000);
    check_eq("R11 now advances", int'(now), 1);

    // R8 R9: table of instruction costs and deferral arms
    dm = 2'b00; t_prev = int'(now); pc_prev = int'(pc);
    for (int i = 0; i < NT; i++) begin
      nx_cyc = TBL[i][3:0]; nx_arm = TBL[i][4];
      wait_exec();
      if (i == 0) check_eq("R8 gap after first exec", int'(now) - t_prev, 1);
      else check_eq("R8 boundary spacing", int'(now) - t_prev,
                    (TBL[i-1][3:0] == 0) ? 1 : int'(TBL[i-1][3:0]));
      check_eq("R8 pc step", int'(pc), pc_prev + 1);
      check_eq("R9 deferral", int'(defer), int'(dm));
      dm = (TBL[i][4] ? 2'b10 : dm) >> 1;
      t_prev = int'(now); pc_prev = int'(pc);
    end
    nx_arm = 0;

    // R7 R5: bus request with bus latch clear is dropped
    nx_iok = 0; nx_cyc = 2;
    wait_exec(); wait_exec();
    base = int'(now) + 1;
    push(1, base + 2, base + 9);
    cnt = 0;
    do begin step(); cnt++; end while (!drop && !busak && cnt < 40);
    check_eq("R7 no busak without latch", int'(busak), 0);
    check_eq("R5 drop seen", int'(drop), 1);
    check_eq("R5 drop at first boundary past end", int'(int'(now) == base + 9 || int'(now) == base + 10), 1);
    step();
    check_eq("R5 boundary after drop", int'(exec), 1);

    // R6 R3: bus grant inside window
    nx_iok = 1; nx_cyc = 1;
    wait_exec(); wait_exec();
    base = int'(now) + 1;
    push(1, base + 5, base + 15);
    cnt = 0;
    do begin step(); if (exec) cnt++; end while (!busak && int'(now) < base + 30);
    check_eq("R6 instructions before window", cnt, 4);
    check_eq("R3 grant at window start", int'(now), base + 5);
    cnt = 0;
    while (busak && cnt < 40) begin cnt++; step(); end
    check_eq("R3 busak length", cnt, 10);
    check_eq("R3 boundary at window end", int'(now), base + 15);
    check_eq("R3 exec at window end", int'(exec), 1);

    // R4: interrupt entry
    nx_ien = 1; nx_iok = 1;
    wait_exec(); wait_exec();
    sp0 = int'(sp); pcg = -1;
    base = int'(now) + 1;
    push(0, base + 4, base + 40);
    cnt = 0;
    do begin
      step(); cnt++;
      if (int'(now) == base + 4) pcg = int'(pc);
    end while (!intak && cnt < 30);
    check_eq("R4 intak cycle", int'(now), base + 6);
    check_eq("R4 stack write", int'(stk_we), 1);
    check_eq("R4 stack address", int'(stk_addr), sp0);
    check_eq("R4 stack data", int'(stk_data), pcg);
    wait_exec();
    check_eq("R4 entry length", int'(now), base + 16);
    check_eq("R4 vector loaded", int'(pc), int'(VEC));
    check_eq("R4 sp incremented", int'(sp), sp0 + 1);

    // R7: interrupt blocked by int_en low
    nx_ien = 0;
    wait_exec(); wait_exec();
    base = int'(now) + 1;
    push(0, base + 3, base + 8);
    cnt = 0;
    do begin step(); cnt++; end while (!drop && !intak && cnt < 30);
    check_eq("R7 no intak with int_en low", int'(intak), 0);
    check_eq("R7 dropped at window end", int'(now), base + 8);

    // R1 R2: reset beats an open bus window
    nx_iok = 1; nx_cyc = 1;
    wait_exec(); wait_exec();
    sp0 = int'(sp);
    base = int'(now) + 1;
    nx_reset = 1;
    push(1, base + 1, base + 61);
    nx_reset = 0;
    step();
    check_eq("R2 reset wins over bus", int'(busak), 0);
    cnt = 0;
    for (int k = 0; k < 5; k++) begin step(); if (dead) cnt++; end
    check_eq("R1 reset dead cycles", cnt, 5);
    step();
    check_eq("R2 first boundary runs instruction", int'(exec), 1);
    check_eq("R1 pc after reset", int'(pc), 16'h1000);
    check_eq("R2 no grant after reset", int'(busak), 0);
    step();
    check_eq("R2 grant once latch reloads", int'(busak), 1);
    check_eq("R2 sp kept across reset", int'(sp), sp0);
    cnt = 0;
    while (busak && cnt < 80) begin cnt++; step(); end

    // R10: five pushes, four held
    nx_iok = 0; nx_cyc = 15;
    wait_exec(); wait_exec();
    base = int'(now);
    nx_cyc = 1;
    for (int k = 0; k < 5; k++) push(1, 0, 1);
    cnt = 0; first = -1;
    for (int k = 0; k < 30; k++) begin
      step();
      if (drop) begin cnt++; if (first < 0) first = int'(now); end
    end
    check_eq("R10 queue depth", cnt, 4);
    check_eq("R10 first drop at boundary", first, base + 15);

    summary();
    $finish;
  end
endmodule